// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a fully associative table of 64 address translations for a 64-bit virtual and 41-bit physical address space. Each entry has its own page size, from 8 KB to 4 MB, chosen by a 2-bit field. An entry can be bound to one 13-bit context or marked global so that it matches under any context. A write port loads an entry at a chosen index. Choosing which entry to replace, and walking page tables to find a new translation, are handled outside the block.

A lookup presents a virtual address, a context, the class of that context, the user or privileged mode, and the access kind (load, store, or no-fault load). The result is combinational. It is either a hit, carrying the translated page address and the granted rights, or a miss, a data fault, or a protection trap. Fault status, the fault address and a tag-access word are registered on the clock edge that ends the lookup. A reader of the status word clears it through a dedicated pulse.

Top module: `tlb_xlate`

## Requirements
- R1: `wr_en_i` loads the entry at `wr_idx_i` on the next clock edge. Attribute bits in `wr_attr_i`: [0] valid, [1] global, [2] privileged-only, [3] side-effect, [4] no-fault-only, [5] writable, [6] invert-endian. An entry with the valid bit clear never hits.
- R2: An entry of size s (0..3) compares virtual address bits [63:13+3s] with its tag. This gives pages of 8 KB, 64 KB, 512 KB and 4 MB.
- R3: A valid entry with a matching tag hits when its global bit is set or its context equals `lk_ctx_i`. Otherwise the lookup misses.
- R4: When several entries hit, the lowest index is reported on `hit_idx_o` and supplies the translation.
- R5: `pa_o` takes bits [40:13+3s] from the entry's physical address and bits [12+3s:13] from the virtual address. Bits [12:0] are zero.
- R6: On a hit, a data fault (`dfault_o`) is raised when any of these holds: a privileged-only page is accessed in user mode; a no-fault load (`lk_kind_i`=2) reaches a side-effect page; any other kind (0 load, 1 store, 3 load) reaches a no-fault-only page. Each of these conditions sets its own status bit, and several may be set together.
- R7: When no data fault occurs, a store (`lk_kind_i`=1) to a page without the writable bit raises `prot_o` instead of a grant.
- R8: A hit with neither a fault nor a trap asserts `rd_ok_o`. It also asserts `wr_ok_o` when the page is writable and `ie_o` when the page is invert-endian, and it sets the entry's bit in `used_o`. Writing an entry clears its used bit.
- R9: A data fault or a protection trap loads `stat_o` and loads `fault_addr_o` with the lookup address. `stat_o` bits: [0] valid, [1] overwrite, [3:2] context class (0 primary, 1 secondary, 2 nucleus), [4] store, [5] no-fault load, [6] privileged mode, [7] privilege fault, [8] side-effect fault, [9] no-fault-only fault. Overwrite is set when the previous status was still valid.
- R10: `stat_clr_i` clears `stat_o` to zero. If a fault occurs in the same cycle, the new status is loaded with overwrite clear.
- R11: A miss asserts `miss_o` and leaves `stat_o` and `fault_addr_o` unchanged.
- R12: A miss, a data fault or a protection trap loads `tag_access_o` with the virtual address, bits [12:0] cleared, ORed with the lookup context. A granted hit leaves it unchanged.
- R13: After reset all entries are invalid, and `stat_o`, `fault_addr_o`, `tag_access_o` and `used_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Load an entry |
| wr_idx_i | input | 6 | Entry index to load |
| wr_va_i | input | 64 | Virtual page address of the new entry |
| wr_ctx_i | input | 13 | Context of the new entry |
| wr_size_i | input | 2 | Page size code of the new entry |
| wr_pa_i | input | 41 | Physical page address of the new entry |
| wr_attr_i | input | 7 | Attribute bits of the new entry (R1) |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 64 | Lookup virtual address |
| lk_ctx_i | input | 13 | Lookup context |
| lk_cls_i | input | 2 | Context class recorded in status |
| lk_user_i | input | 1 | User mode when high |
| lk_kind_i | input | 2 | 0 load, 1 store, 2 no-fault load, 3 load |
| stat_clr_i | input | 1 | Clear the status word |
| hit_o | output | 1 | An entry matched |
| miss_o | output | 1 | No entry matched |
| hit_idx_o | output | 6 | Index of the matching entry |
| pa_o | output | 41 | Translated page address |
| rd_ok_o | output | 1 | Access granted |
| wr_ok_o | output | 1 | Granted and writable |
| ie_o | output | 1 | Granted page is invert-endian |
| dfault_o | output | 1 | Data fault |
| prot_o | output | 1 | Protection trap |
| stat_o | output | 10 | Fault status word |
| fault_addr_o | output | 64 | Address of the last fault |
| tag_access_o | output | 64 | Page address and context of the last miss or fault |
| used_o | output | 64 | Per-entry used bits |

## Verification
The assertions assume that the write port and the lookup never target the same entry in the same cycle. They also assume that the lookup inputs are held steady for the whole cycle in which `lk_valid_i` is high. The stimulus keeps to both: table loads and lookups happen in separate phases, and every lookup is driven just after a clock edge and released just after the next one. Duplicate entries with an identical tag are created on purpose, so that the lowest-index rule is exercised.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W    = 64;
  parameter int PA_W    = 41;
  parameter int CTX_W   = 13;
  parameter int PG_LSB  = 13;
  parameter int SZ_W    = 2;
  parameter int SZ_STEP = 3;
  parameter int ATTR_W  = 7;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_NFLD  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // valid is bit 0 so a raw attribute word casts directly
  typedef struct packed {
    logic ie;
    logic wok;
    logic nfo;
    logic side;
    logic priv;
    logic glob;
    logic valid;
  } attr_t;

  typedef struct packed {
    attr_t                   attr;
    logic [CTX_W-1:0]        ctx;
    logic [SZ_W-1:0]         size;
    logic [VA_W-1:PG_LSB]    tag;
    logic [PA_W-1:PG_LSB]    pfn;
  } entry_t;

  typedef struct packed {
    logic       ft_nfo;
    logic       ft_side;
    logic       ft_priv;
    logic       priv_mode;
    logic       nf;
    logic       wr;
    logic [1:0] cls;
    logic       ow;
    logic       valid;
  } stat_t;

  function automatic logic [VA_W-1:0] va_mask(logic [SZ_W-1:0] sz);
    return {VA_W{1'b1}} << (PG_LSB + SZ_STEP * int'(sz));
  endfunction

  function automatic logic [PA_W-1:0] pa_mask(logic [SZ_W-1:0] sz);
    return {PA_W{1'b1}} << (PG_LSB + SZ_STEP * int'(sz));
  endfunction
endpackage

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store import tlb_pkg::*; #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  entry_t               wr_entry_i,
  input  logic [VA_W-1:0]      lk_va_i,
  input  logic [CTX_W-1:0]     lk_ctx_i,
  input  logic                 touch_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [ENTRIES-1:0]   match_o,
  output logic [ENTRIES-1:0]   used_o,
  output logic [PA_W-1:PG_LSB] rd_pfn_o,
  output logic [SZ_W-1:0]      rd_size_o,
  output logic                 rd_priv_o,
  output logic                 rd_side_o,
  output logic                 rd_nfo_o,
  output logic                 rd_wok_o,
  output logic                 rd_ie_o
);
  logic [PA_W-1:PG_LSB] pfn_arr  [ENTRIES];
  logic [SZ_W-1:0]      size_arr [ENTRIES];
  logic [4:0]           perm_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gen_ent
    entry_t ent_q;
    logic   used_q;
    logic   wr_sel;

    assign wr_sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q  <= '0;
        used_q <= 1'b0;
      end else if (wr_sel) begin
        ent_q  <= wr_entry_i;
        used_q <= 1'b0;
      end else if (touch_i && (rd_idx_i == IDX_W'(g))) begin
        used_q <= 1'b1;
      end
    end

    assign match_o[g] = ent_q.attr.valid
                     && (((lk_va_i ^ {ent_q.tag, {PG_LSB{1'b0}}}) & va_mask(ent_q.size)) == '0)
                     && (ent_q.attr.glob || (ent_q.ctx == lk_ctx_i));
    assign used_o[g]   = used_q;
    assign pfn_arr[g]  = ent_q.pfn;
    assign size_arr[g] = ent_q.size;
    assign perm_arr[g] = {ent_q.attr.ie, ent_q.attr.wok, ent_q.attr.nfo,
                          ent_q.attr.side, ent_q.attr.priv};
  end

  assign rd_pfn_o  = pfn_arr[rd_idx_i];
  assign rd_size_o = size_arr[rd_idx_i];
  assign {rd_ie_o, rd_wok_o, rd_nfo_o, rd_side_o, rd_priv_o} = perm_arr[rd_idx_i];
endmodule

// File: rtl/tlb_fault_regs.sv
module tlb_fault_regs import tlb_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             miss_i,
  input  logic             fault_i,
  input  logic             clr_i,
  input  stat_t            stat_new_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [CTX_W-1:0] ctx_i,
  output stat_t            stat_o,
  output logic [VA_W-1:0]  fault_addr_o,
  output logic [VA_W-1:0]  tag_access_o
);
  stat_t           stat_q;
  logic [VA_W-1:0] fault_addr_q;
  logic [VA_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q       <= '0;
      fault_addr_q <= '0;
    end else if (fault_i) begin
      stat_q       <= stat_new_i;
      stat_q.valid <= 1'b1;
      stat_q.ow    <= stat_q.valid && !clr_i;
      fault_addr_q <= va_i;
    end else if (clr_i) begin
      stat_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tag_q <= '0;
    else if (fire_i && (miss_i || fault_i))
      tag_q <= {va_i[VA_W-1:PG_LSB], {PG_LSB{1'b0}}} | VA_W'(ctx_i);
  end

  assign stat_o       = stat_q;
  assign fault_addr_o = fault_addr_q;
  assign tag_access_o = tag_q;

  a_r9_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && stat_q.valid && !clr_i) |=> (stat_q.valid && stat_q.ow));
  a_r9_fault_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (fault_addr_q == $past(va_i)));
  a_r11_miss_keeps_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && miss_i && !clr_i) |=> ($stable(stat_q) && $stable(fault_addr_q)));
  a_r12_tag_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && (miss_i || fault_i)) |=>
      (tag_q[VA_W-1:PG_LSB] == $past(va_i[VA_W-1:PG_LSB])
       && tag_q[CTX_W-1:0] == $past(ctx_i)));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate import tlb_pkg::*; #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [VA_W-1:0]    wr_va_i,
  input  logic [CTX_W-1:0]   wr_ctx_i,
  input  logic [SZ_W-1:0]    wr_size_i,
  input  logic [PA_W-1:0]    wr_pa_i,
  input  logic [ATTR_W-1:0]  wr_attr_i,
  input  logic               lk_valid_i,
  input  logic [VA_W-1:0]    lk_va_i,
  input  logic [CTX_W-1:0]   lk_ctx_i,
  input  logic [1:0]         lk_cls_i,
  input  logic               lk_user_i,
  input  logic [1:0]         lk_kind_i,
  input  logic               stat_clr_i,
  output logic               hit_o,
  output logic               miss_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic [PA_W-1:0]    pa_o,
  output logic               rd_ok_o,
  output logic               wr_ok_o,
  output logic               ie_o,
  output logic               dfault_o,
  output logic               prot_o,
  output logic [9:0]         stat_o,
  output logic [VA_W-1:0]    fault_addr_o,
  output logic [VA_W-1:0]    tag_access_o,
  output logic [ENTRIES-1:0] used_o
);
  entry_t               wr_entry;
  logic [ENTRIES-1:0]   match_vec;
  logic                 found;
  logic [IDX_W-1:0]     idx;
  logic [PA_W-1:PG_LSB] pfn;
  logic [SZ_W-1:0]      size;
  logic                 e_priv, e_side, e_nfo, e_wok, e_ie;
  logic [PA_W-1:0]      pmask, pa_full;
  acc_kind_e            kind;
  logic                 ft_priv, ft_side, ft_nfo, any_df, trap, grant;
  stat_t                stat_new, stat_q;

  assign kind     = acc_kind_e'(lk_kind_i);
  assign wr_entry = '{attr: attr_t'(wr_attr_i), ctx: wr_ctx_i, size: wr_size_i,
                      tag: wr_va_i[VA_W-1:PG_LSB], pfn: wr_pa_i[PA_W-1:PG_LSB]};

  tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_idx_i, .wr_entry_i(wr_entry),
    .lk_va_i, .lk_ctx_i,
    .touch_i(grant), .rd_idx_i(idx),
    .match_o(match_vec), .used_o,
    .rd_pfn_o(pfn), .rd_size_o(size),
    .rd_priv_o(e_priv), .rd_side_o(e_side), .rd_nfo_o(e_nfo),
    .rd_wok_o(e_wok), .rd_ie_o(e_ie)
  );

  tlb_first_hit #(.N(ENTRIES)) u_first (
    .req_i(match_vec), .found_o(found), .idx_o(idx)
  );

  assign pmask   = pa_mask(size);
  assign pa_full = ({pfn, {PG_LSB{1'b0}}} & pmask) | (lk_va_i[PA_W-1:0] & ~pmask);

  assign hit_o     = lk_valid_i && found;
  assign miss_o    = lk_valid_i && !found;
  assign hit_idx_o = idx;
  assign pa_o      = {pa_full[PA_W-1:PG_LSB], {PG_LSB{1'b0}}};

  // checks are ordered: data faults first, write permission only without them
  assign ft_priv = hit_o && e_priv && lk_user_i;
  assign ft_side = hit_o && (kind == ACC_NFLD) && e_side;
  assign ft_nfo  = hit_o && (kind != ACC_NFLD) && e_nfo;
  assign any_df  = ft_priv || ft_side || ft_nfo;
  assign trap    = hit_o && !any_df && (kind == ACC_STORE) && !e_wok;
  assign grant   = hit_o && !any_df && !trap;

  assign dfault_o = any_df;
  assign prot_o   = trap;
  assign rd_ok_o  = grant;
  assign wr_ok_o  = grant && e_wok;
  assign ie_o     = grant && e_ie;

  always_comb begin
    stat_new           = '0;
    stat_new.ft_nfo    = ft_nfo;
    stat_new.ft_side   = ft_side;
    stat_new.ft_priv   = ft_priv;
    stat_new.priv_mode = !lk_user_i;
    stat_new.nf        = (kind == ACC_NFLD);
    stat_new.wr        = (kind == ACC_STORE);
    stat_new.cls       = lk_cls_i;
  end

  tlb_fault_regs u_fregs (
    .clk_i, .rst_ni,
    .fire_i(lk_valid_i), .miss_i(miss_o), .fault_i(any_df || trap),
    .clr_i(stat_clr_i), .stat_new_i(stat_new),
    .va_i(lk_va_i), .ctx_i(lk_ctx_i),
    .stat_o(stat_q), .fault_addr_o, .tag_access_o
  );

  assign stat_o = stat_q;

  a_r4_lowest_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_vec[hit_idx_o]
               && ((match_vec & ((ENTRIES'(1) << hit_idx_o) - ENTRIES'(1))) == '0)));
  a_r8_used_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok_o && !(wr_en_i && wr_idx_i == hit_idx_o)) |=> used_o[$past(hit_idx_o)]);
  a_r7_trap_not_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_o |-> (!dfault_o && !rd_ok_o && hit_o));
endmodule

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_idx_i = '0;
  logic [63:0] wr_va_i = '0;
  logic [12:0] wr_ctx_i = '0;
  logic [1:0]  wr_size_i = '0;
  logic [40:0] wr_pa_i = '0;
  logic [6:0]  wr_attr_i = '0;
  logic        lk_valid_i = 1'b0;
  logic [63:0] lk_va_i = '0;
  logic [12:0] lk_ctx_i = '0;
  logic [1:0]  lk_cls_i = '0;
  logic        lk_user_i = 1'b0;
  logic [1:0]  lk_kind_i = '0;
  logic        stat_clr_i = 1'b0;
  logic        hit_o, miss_o, rd_ok_o, wr_ok_o, ie_o, dfault_o, prot_o;
  logic [5:0]  hit_idx_o;
  logic [40:0] pa_o;
  logic [9:0]  stat_o;
  logic [63:0] fault_addr_o, tag_access_o, used_o;

  tlb_xlate u_tlb_xlate (.*);

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    bit          is_reg;
    string       req;
    logic        hit, miss, rd, wr, ie, df, pr;
    logic [5:0]  idx;
    logic [40:0] pa;
    logic [9:0]  st;
    logic [63:0] fa, ta, used;
  } item_t;

  item_t q[$];
  item_t it;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] m_va   [64];
  logic [12:0] m_ctx  [64];
  logic [1:0]  m_sz   [64];
  logic [40:0] m_pa   [64];
  logic [6:0]  m_attr [64];
  logic [9:0]  e_st   = '0;
  logic [63:0] e_fa   = '0;
  logic [63:0] e_ta   = '0;
  logic [63:0] e_used = '0;

  initial for (int i = 0; i < 64; i++) begin
    m_va[i] = '0; m_ctx[i] = '0; m_sz[i] = '0; m_pa[i] = '0; m_attr[i] = '0;
  end

  // monitor: one expected item per negedge
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      bit bad;
      it = q.pop_front();
      checks++;
      if (it.is_reg)
        bad = (stat_o !== it.st) || (fault_addr_o !== it.fa) ||
              (tag_access_o !== it.ta) || (used_o !== it.used);
      else
        bad = (hit_o !== it.hit) || (miss_o !== it.miss) || (rd_ok_o !== it.rd) ||
              (wr_ok_o !== it.wr) || (ie_o !== it.ie) || (dfault_o !== it.df) ||
              (prot_o !== it.pr) ||
              (it.hit && ((hit_idx_o !== it.idx) || (pa_o !== it.pa)));
      if (bad) begin
        fails++;
        if (it.is_reg)
          $display("FAIL %s regs: st=%h fa=%h ta=%h used=%h exp st=%h fa=%h ta=%h used=%h",
                   it.req, stat_o, fault_addr_o, tag_access_o, used_o,
                   it.st, it.fa, it.ta, it.used);
        else
          $display("FAIL %s lookup: hit=%b miss=%b idx=%0d pa=%h rd=%b wr=%b ie=%b df=%b pr=%b exp hit=%b miss=%b idx=%0d pa=%h rd=%b wr=%b ie=%b df=%b pr=%b",
                   it.req, hit_o, miss_o, hit_idx_o, pa_o, rd_ok_o, wr_ok_o, ie_o, dfault_o, prot_o,
                   it.hit, it.miss, it.idx, it.pa, it.rd, it.wr, it.ie, it.df, it.pr);
      end
    end
  end

  task automatic push_regs(string req);
    item_t r;
    r.is_reg = 1; r.req = req;
    r.st = e_st; r.fa = e_fa; r.ta = e_ta; r.used = e_used;
    q.push_back(r);
  endtask

  task automatic wr_ent(int idx, logic [63:0] va, logic [12:0] ctx, logic [1:0] sz,
                        logic [40:0] pa, logic [6:0] attr);
    @(posedge clk_i); #1;
    wr_en_i = 1; wr_idx_i = 6'(idx); wr_va_i = va; wr_ctx_i = ctx;
    wr_size_i = sz; wr_pa_i = pa; wr_attr_i = attr;
    @(posedge clk_i); #1;
    wr_en_i = 0;
    m_va[idx] = va; m_ctx[idx] = ctx; m_sz[idx] = sz; m_pa[idx] = pa; m_attr[idx] = attr;
    e_used[idx] = 1'b0;
  endtask

  task automatic lookup(logic [63:0] va, logic [12:0] ctx, logic [1:0] cls, bit user,
                        logic [1:0] kind, bit clr, string req);
    item_t c;
    bit found = 0;
    int k = 0;
    logic [63:0] mask;
    logic [40:0] m41;
    bit fp, fs, fn, df, pr, gr;
    @(posedge clk_i); #1;
    lk_valid_i = 1; lk_va_i = va; lk_ctx_i = ctx; lk_cls_i = cls;
    lk_user_i = user; lk_kind_i = kind; stat_clr_i = clr;
    for (int i = 0; i < 64; i++) begin
      mask = ~64'h0 << (13 + 3 * int'(m_sz[i]));
      if (!found && m_attr[i][0] && (((va ^ m_va[i]) & mask) == 0) &&
          (m_attr[i][1] || m_ctx[i] == ctx)) begin
        found = 1; k = i;
      end
    end
    m41 = (~64'h0 << (13 + 3 * int'(m_sz[k])));
    fp = found && m_attr[k][2] && user;
    fs = found && (kind == 2'd2) && m_attr[k][3];
    fn = found && (kind != 2'd2) && m_attr[k][4];
    df = fp || fs || fn;
    pr = found && !df && (kind == 2'd1) && !m_attr[k][5];
    gr = found && !df && !pr;
    c.is_reg = 0; c.req = req;
    c.hit = found; c.miss = !found; c.idx = 6'(k);
    c.pa = ((m_pa[k] & m41) | (va[40:0] & ~m41)) & ~41'h1FFF;
    c.rd = gr; c.wr = gr && m_attr[k][5]; c.ie = gr && m_attr[k][6];
    c.df = df; c.pr = pr;
    q.push_back(c);
    if (df || pr) begin
      e_st = {fn, fs, fp, !user, kind == 2'd2, kind == 2'd1, cls, e_st[0] && !clr, 1'b1};
      e_fa = va;
    end else if (clr) e_st = '0;
    if (!found || df || pr) e_ta = {va[63:13], 13'h0} | 64'(ctx);
    if (gr) e_used[k] = 1'b1;
    @(posedge clk_i); #1;
    lk_valid_i = 0; stat_clr_i = 0;
    push_regs(req);
  endtask

  task automatic clear_stat(string req);
    @(posedge clk_i); #1;
    stat_clr_i = 1;
    @(posedge clk_i); #1;
    stat_clr_i = 0;
    e_st = '0;
    push_regs(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    item_t z;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    // R13: reset state, no lookup active
    z.is_reg = 0; z.req = "R13"; z.hit = 0; z.miss = 0; z.rd = 0; z.wr = 0;
    z.ie = 0; z.df = 0; z.pr = 0; z.idx = 0; z.pa = 0;
    q.push_back(z);
    @(posedge clk_i); #1;
    push_regs("R13");

    wr_ent(0, 64'h0000_0000_1234_6000, 13'd5, 2'd0, 41'h1_2345_6000, 7'h61);
    wr_ent(1, 64'h0000_0040_0001_0000, 13'd9, 2'd1, 41'h0_7770_0000, 7'h03);
    wr_ent(2, 64'hFFFF_FFFF_8008_0000, 13'd5, 2'd2, 41'h0_0100_0000, 7'h25);
    wr_ent(3, 64'h0000_0000_0040_0000, 13'd7, 2'd3, 41'h1_0000_0000, 7'h29);
    wr_ent(4, 64'h0000_0000_0000_2000, 13'd5, 2'd0, 41'h0_0000_4000, 7'h11);
    wr_ent(5, 64'h0000_0000_1234_6000, 13'd5, 2'd0, 41'h0_5555_4000, 7'h01);
    wr_ent(6, 64'h0000_0000_0000_9000, 13'd5, 2'd0, 41'h0_0000_9000, 7'h00);
    wr_ent(7, 64'h0000_0000_0000_A000, 13'd5, 2'd0, 41'h0_0000_A000, 7'h15);

    lookup(64'h0000_0000_1234_6123, 13'd5, 2'd0, 0, 2'd0, 0, "R4 R5 R8 lowest");
    lookup(64'h0000_0000_1234_6FF0, 13'd5, 2'd0, 0, 2'd1, 0, "R8 store grant");
    lookup(64'h0000_0000_1234_6000, 13'd6, 2'd1, 0, 2'd0, 0, "R3 R11 R12 ctx miss");
    lookup(64'h0000_0040_0001_ABCD, 13'd3, 2'd0, 0, 2'd0, 0, "R2 R3 R5 global 64K");
    lookup(64'h0000_0040_0001_E000, 13'd3, 2'd1, 0, 2'd1, 0, "R7 R9 prot");
    lookup(64'h0000_0040_0002_0000, 13'd9, 2'd0, 0, 2'd0, 0, "R2 outside 64K");
    lookup(64'hFFFF_FFFF_800F_F000, 13'd5, 2'd0, 1, 2'd0, 0, "R6 R9 priv overwrite");
    clear_stat("R10 clear");
    lookup(64'h0000_0000_007F_E000, 13'd7, 2'd2, 0, 2'd2, 0, "R6 side-effect");
    lookup(64'h0000_0000_0000_2010, 13'd5, 2'd0, 0, 2'd0, 0, "R6 nfo");
    lookup(64'h0000_0000_0000_2020, 13'd5, 2'd0, 0, 2'd1, 1, "R10 clear with fault");
    lookup(64'h0000_0000_0000_2030, 13'd5, 2'd0, 0, 2'd2, 0, "R6 nf load on nfo page");
    lookup(64'h0000_0000_0000_A000, 13'd5, 2'd0, 1, 2'd3, 0, "R6 accumulate");
    lookup(64'h0000_0000_0000_9000, 13'd5, 2'd0, 0, 2'd0, 0, "R1 R11 invalid entry");
    lookup(64'h0000_0000_005A_6000, 13'd7, 2'd0, 0, 2'd1, 0, "R2 R5 R8 4M store");
    lookup(64'hFFFF_FFFF_8008_0000, 13'd1, 2'd0, 0, 2'd0, 0, "R3 R11 ctx mismatch");
    wr_ent(0, 64'h0000_0000_1234_6000, 13'd5, 2'd0, 41'h1_2345_6000, 7'h61);
    push_regs("R8 rewrite clears used");
    wr_ent(6, 64'h0000_0000_0000_9000, 13'd5, 2'd0, 41'h0_0000_9000, 7'h01);
    lookup(64'h0000_0000_0000_9000, 13'd5, 2'd0, 0, 2'd0, 0, "R1 now valid");
    lookup(64'h0000_0000_1234_6000, 13'd5, 2'd0, 0, 2'd0, 0, "R4 R8 re-hit");

    repeat (3) @(posedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule